// File: doc/BRIEF.md
# Eight-Stage Pipeline Load-Use and Branch Interlock

This block is the hazard controller for an in-order integer pipeline of eight stages: IF, IS, RF, EX, DF, DS, TC, WB. Hazard checking is done while an instruction sits in RF. There it is compared against the four older instructions held in EX, DF, DS and TC. Load data comes out of a data-cache access split over DF and DS, so it can be forwarded only once the load has left DS. A consumer that reads a load result therefore has to wait in RF while the load is in EX or DF. For every source operand the block also picks the youngest older producer of that register. It registers that choice so that the EX operand multiplexers can use it in the next cycle.

Branches are predicted not taken, and each branch has one architectural delay slot. The branch outcome is known in EX. When a branch in EX is taken, the delay-slot instruction in RF goes on unaffected. The two wrong-path instructions in IS and IF are squashed, which gives two bubbles. The datapath, the fetch redirect and cache-miss handling lie outside this block.

Top module: `hzd_interlock`

## Requirements
- R1: While reset is held and right after it, both registered forwarding selects read 0, meaning the register file.
- R2: A load in EX (producer slot 0) whose destination matches a source in a valid RF instruction raises stall_o. A consumer directly behind a load therefore stalls for two cycles, while the load is in EX and then while it is in DF.
- R3: A load in DF (slot 1) that matches raises stall_o. A consumer two behind a load therefore stalls one cycle. A load in DS (slot 2) or TC (slot 3) never stalls, and the consumer is forwarded with select 3 or 4.
- R4: The forwarding select of each source, registered on a non-stall cycle, names the youngest valid matching writer: 1 = EX, 2 = DF, 3 = DS, 4 = TC, 0 = none. Writers are class 1 (ALU) and class 2 (load).
- R5: Source register 0 never matches, never stalls and always gets select 0.
- R6: Only the youngest matching producer decides a stall. An older load that is shadowed by a younger ALU writer of the same register does not stall. A load younger than a matching ALU instruction does stall.
- R7: On a cycle with stall_o high, both registered selects become 0 in the next cycle, because a bubble enters EX.
- R8: squash_o is 2'b11 (bit 0 = IF, bit 1 = IS) exactly when slot 0 is valid, holds class 3 (branch) and br_taken_i is high. Otherwise it is 2'b00. Squashing does not change stall_o for the delay-slot instruction in RF.
- R9: An invalid RF instruction never stalls and gets select 0. Invalid producers, and producers of class 0 (other) or 3 (branch), never match.
- R10: Both sources are checked independently. When both name the same register, both get the same select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_vld_i | input | 1 | RF stage holds a valid instruction |
| rf_rs1_i | input | REG_W | First source register of the RF instruction (0 if unused) |
| rf_rs2_i | input | REG_W | Second source register of the RF instruction (0 if unused) |
| prod_vld_i | input | 4 | Valid flags for slots EX, DF, DS, TC (bit 0 = EX) |
| prod_cls_i | input | 8 | Class per slot, 2 bits each: 0 other, 1 ALU, 2 load, 3 branch |
| prod_rd_i | input | 4*REG_W | Destination register per slot, slot 0 in the low bits |
| br_taken_i | input | 1 | Branch outcome resolved in EX |
| stall_o | output | 1 | Hold IF, IS and RF and insert a bubble into EX |
| squash_o | output | 2 | Invalidate IF (bit 0) and IS (bit 1) |
| fwd_rs1_o | output | 3 | Registered forwarding select for the first source in EX |
| fwd_rs2_o | output | 3 | Registered forwarding select for the second source in EX |

## Verification
A load is walked from EX through DS at distances one, two and three from its consumer. These runs tell the two-cycle, one-cycle and zero-cycle penalties apart, and show the select that follows each stall. Stage snapshots with several writers of the same register, in different orders of age, separate the youngest producer from an older one. The same kind of snapshot separates a shadowed load from a live one. Register zero, invalid slots, non-writing classes and a taken flag seen without a branch in EX check that no false hazard or squash arises. Taken and not-taken branches, including a taken branch during a load stall, check the squash pair.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NPROD = 4;                  // EX, DF, DS, TC
  localparam int SEL_W = $clog2(NPROD + 1);
  localparam int LD_WAIT = 2;                // slots where load data is not ready yet
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    CLS_OTH = 2'd0,
    CLS_ALU = 2'd1,
    CLS_LD  = 2'd2,
    CLS_BR  = 2'd3
  } cls_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]       src_i,
  input  logic [NPROD-1:0]       prod_vld_i,
  input  logic [2*NPROD-1:0]     prod_cls_i,
  input  logic [NPROD*REG_W-1:0] prod_rd_i,
  output logic [SEL_W-1:0]       sel_o,
  output logic                   ld_block_o
);
  logic [NPROD-1:0] hit;
  logic [NPROD-1:0] is_ld;

  for (genvar i = 0; i < NPROD; i++) begin : g_slot
    cls_e cls;
    assign cls      = cls_e'(prod_cls_i[2*i +: 2]);
    assign is_ld[i] = (cls == CLS_LD);
    assign hit[i]   = prod_vld_i[i] && (cls == CLS_ALU || cls == CLS_LD)
                      && (prod_rd_i[REG_W*i +: REG_W] == src_i)
                      && (src_i != '0);
  end

  // oldest first, so the youngest hit wins
  always_comb begin
    sel_o      = '0;
    ld_block_o = 1'b0;
    for (int i = NPROD - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_o      = SEL_W'(i + 1);
        ld_block_o = is_ld[i] && (i < LD_WAIT);
      end
    end
  end
endmodule

// File: rtl/hzd_branch.sv
module hzd_branch
  import hzd_pkg::*;
(
  input  logic       ex_vld_i,
  input  logic [1:0] ex_cls_i,
  input  logic       taken_i,
  output logic [1:0] squash_o
);
  logic kill;
  assign kill     = ex_vld_i && (cls_e'(ex_cls_i) == CLS_BR) && taken_i;
  assign squash_o = {2{kill}};
endmodule

// File: rtl/hzd_fwd_reg.sv
module hzd_fwd_reg
  import hzd_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bubble_i,
  input  logic [NSRC-1:0][SEL_W-1:0] sel_d_i,
  output logic [NSRC-1:0][SEL_W-1:0] sel_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q_o <= '0;
    else if (bubble_i) sel_q_o <= '0;
    else               sel_q_o <= sel_d_i;
  end
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rf_vld_i,
  input  logic [REG_W-1:0]       rf_rs1_i,
  input  logic [REG_W-1:0]       rf_rs2_i,
  input  logic [NPROD-1:0]       prod_vld_i,
  input  logic [2*NPROD-1:0]     prod_cls_i,
  input  logic [NPROD*REG_W-1:0] prod_rd_i,
  input  logic                   br_taken_i,
  output logic                   stall_o,
  output logic [1:0]             squash_o,
  output logic [SEL_W-1:0]       fwd_rs1_o,
  output logic [SEL_W-1:0]       fwd_rs2_o
);
  logic [NSRC-1:0][REG_W-1:0] src;
  logic [NSRC-1:0][SEL_W-1:0] sel_raw, sel_d, sel_q;
  logic [NSRC-1:0]            blk;

  assign src[0] = rf_rs1_i;
  assign src[1] = rf_rs2_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hzd_src_match #(.REG_W(REG_W)) u_match (
      .src_i      (src[s]),
      .prod_vld_i (prod_vld_i),
      .prod_cls_i (prod_cls_i),
      .prod_rd_i  (prod_rd_i),
      .sel_o      (sel_raw[s]),
      .ld_block_o (blk[s])
    );
    assign sel_d[s] = rf_vld_i ? sel_raw[s] : '0;
  end

  assign stall_o = rf_vld_i && (|blk);

  hzd_fwd_reg u_fwd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bubble_i (stall_o),
    .sel_d_i  (sel_d),
    .sel_q_o  (sel_q)
  );

  assign fwd_rs1_o = sel_q[0];
  assign fwd_rs2_o = sel_q[1];

  hzd_branch u_br (
    .ex_vld_i (prod_vld_i[0]),
    .ex_cls_i (prod_cls_i[1:0]),
    .taken_i  (br_taken_i),
    .squash_o (squash_o)
  );
endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rf_vld_i,
  input logic [REG_W-1:0] rf_rs1_i,
  input logic [REG_W-1:0] rf_rs2_i,
  input logic [3:0]       prod_vld_i,
  input logic [7:0]       prod_cls_i,
  input logic             br_taken_i,
  input logic             stall_o,
  input logic [1:0]       squash_o,
  input logic [2:0]       fwd_rs1_o,
  input logic [2:0]       fwd_rs2_o
);
  // R9
  idle_rf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_vld_i |-> !stall_o);

  // R7
  stall_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (fwd_rs1_o == 3'd0 && fwd_rs2_o == 3'd0));

  // R8
  squash_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o == 2'b00 || squash_o == 2'b11);

  // R8
  squash_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o != 2'b00 |-> (prod_vld_i[0] && prod_cls_i[1:0] == 2'd3 && br_taken_i));

  // R5
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_rs1_i == '0 && rf_rs2_i == '0) |-> !stall_o);

  // R5
  zero_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_rs1_i == '0) |=> fwd_rs1_o == 3'd0);

  // R4
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_rs1_o <= 3'd4 && fwd_rs2_o <= 3'd4);
endmodule

bind hzd_interlock hzd_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rf_vld_i   (rf_vld_i),
  .rf_rs1_i   (rf_rs1_i),
  .rf_rs2_i   (rf_rs2_i),
  .prod_vld_i (prod_vld_i),
  .prod_cls_i (prod_cls_i),
  .br_taken_i (br_taken_i),
  .stall_o    (stall_o),
  .squash_o   (squash_o),
  .fwd_rs1_o  (fwd_rs1_o),
  .fwd_rs2_o  (fwd_rs2_o)
);

// File: tb/hzd_interlock_bench.sv
module hzd_interlock_bench;
  localparam int RW = 5;
  localparam logic [1:0] OTH = 2'd0, ALU = 2'd1, LD = 2'd2, BR = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rf_vld = 1'b0;
  logic [RW-1:0] rs1 = '0, rs2 = '0;
  logic [3:0]    p_vld = '0;
  logic [7:0]    p_cls = '0;
  logic [19:0]   p_rd = '0;
  logic          br_tk = 1'b0;
  logic          stall;
  logic [1:0]    squash;
  logic [2:0]    f1, f2;

  logic [3:0]  n_vld = '0;
  logic [7:0]  n_cls = '0;
  logic [19:0] n_rd = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic       st;
    logic [1:0] sq;
    logic [2:0] e1;
    logic [2:0] e2;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  hzd_interlock #(.REG_W(RW)) u_hzd_interlock (
    .clk_i(clk), .rst_ni(rst_n), .rf_vld_i(rf_vld), .rf_rs1_i(rs1), .rf_rs2_i(rs2),
    .prod_vld_i(p_vld), .prod_cls_i(p_cls), .prod_rd_i(p_rd), .br_taken_i(br_tk),
    .stall_o(stall), .squash_o(squash), .fwd_rs1_o(f1), .fwd_rs2_o(f2)
  );

  task automatic put(input int i, input logic [1:0] c, input logic [RW-1:0] rd);
    n_vld[i]        = 1'b1;
    n_cls[2*i +: 2] = c;
    n_rd[RW*i +: RW] = rd;
  endtask

  task automatic clr();
    n_vld = '0; n_cls = '0; n_rd = '0;
  endtask

  task automatic step(input logic rv, input logic [RW-1:0] a, input logic [RW-1:0] b,
                      input logic bt, input logic es, input logic [1:0] esq,
                      input logic [2:0] ea, input logic [2:0] eb, input string tag);
    exp_t it;
    @(posedge clk); #2;
    rf_vld = rv; rs1 = a; rs2 = b; br_tk = bt;
    p_vld = n_vld; p_cls = n_cls; p_rd = n_rd;
    it.st = es; it.sq = esq; it.e1 = ea; it.e2 = eb; it.tag = tag;
    q.push_back(it);
    clr();
  endtask

  // monitor
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (stall !== it.st || squash !== it.sq) begin
          errors++;
          $display("FAIL %s stall/squash: got %b/%b expected %b/%b", it.tag, stall, squash, it.st, it.sq);
        end
        @(posedge clk); #1;
        checks++;
        if (f1 !== it.e1 || f2 !== it.e2) begin
          errors++;
          $display("FAIL %s selects: got %0d/%0d expected %0d/%0d", it.tag, f1, f2, it.e1, it.e2);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (f1 !== 3'd0 || f2 !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset selects: got %0d/%0d expected 0/0", f1, f2);
    end
    @(posedge clk); #2; rst_n = 1'b1;

    step(1'b0, 0, 0, 0, 0, 2'b00, 0, 0, "R1");
    // R4 single producer in TC
    put(3, ALU, 7);
    step(1'b1, 7, 0, 0, 0, 2'b00, 4, 0, "R4");
    // R4 youngest of several writers
    put(0, ALU, 7); put(1, ALU, 9); put(2, ALU, 7);
    step(1'b1, 7, 9, 0, 0, 2'b00, 1, 2, "R4");
    // R10 both sources same register
    put(3, ALU, 12);
    step(1'b1, 12, 12, 0, 0, 2'b00, 4, 4, "R10");
    // R5 register zero
    put(0, ALU, 0); put(1, LD, 0);
    step(1'b1, 0, 0, 0, 0, 2'b00, 0, 0, "R5");
    // R9 invalid RF
    put(0, LD, 3);
    step(1'b0, 3, 0, 0, 0, 2'b00, 0, 0, "R9");
    // R9 non-writers and invalid producer
    put(0, BR, 4); put(1, OTH, 4); put(2, ALU, 4); n_vld[2] = 1'b0;
    step(1'b1, 4, 0, 0, 0, 2'b00, 0, 0, "R9");
    // R2 load directly ahead: two stalls then DS forward (R7 bubble selects)
    put(0, LD, 5); put(3, ALU, 1);
    step(1'b1, 1, 5, 0, 1, 2'b00, 0, 0, "R2_R7");
    put(1, LD, 5); put(3, ALU, 1);
    step(1'b1, 1, 5, 0, 1, 2'b00, 0, 0, "R2_R7");
    put(2, LD, 5); put(3, ALU, 1);
    step(1'b1, 1, 5, 0, 0, 2'b00, 4, 3, "R2");
    // R3 load two ahead: one stall
    put(1, LD, 6);
    step(1'b1, 6, 0, 0, 1, 2'b00, 0, 0, "R3");
    put(2, LD, 6);
    step(1'b1, 6, 0, 0, 0, 2'b00, 3, 0, "R3");
    // R3 load three ahead and in TC: no stall
    put(2, LD, 8);
    step(1'b1, 0, 8, 0, 0, 2'b00, 0, 3, "R3");
    put(3, LD, 11);
    step(1'b1, 11, 0, 0, 0, 2'b00, 4, 0, "R3");
    // R6 shadowed load
    put(0, ALU, 5); put(1, LD, 5);
    step(1'b1, 5, 0, 0, 0, 2'b00, 1, 0, "R6");
    // R6 load younger than ALU
    put(0, LD, 5); put(1, ALU, 5);
    step(1'b1, 5, 0, 0, 1, 2'b00, 0, 0, "R6");
    // R8 taken / not taken / taken during stall / flag without branch
    put(0, BR, 0);
    step(1'b1, 0, 0, 1, 0, 2'b11, 0, 0, "R8");
    put(0, BR, 0);
    step(1'b1, 0, 0, 0, 0, 2'b00, 0, 0, "R8");
    put(0, BR, 0); put(1, LD, 2);
    step(1'b1, 2, 0, 1, 1, 2'b11, 0, 0, "R8");
    put(0, ALU, 9);
    step(1'b1, 9, 0, 1, 0, 2'b00, 1, 0, "R8");
    step(1'b0, 0, 0, 0, 0, 2'b00, 0, 0, "R1");

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule